// File: doc/BRIEF.md
# PWM Channel Gate and Interrupt Controller

This block is the shared control point for a group of PWM channels. For each channel it keeps a run bit, driven straight out to that channel's counter as an enable, and an interrupt mask bit. It also collects the one-cycle period-end pulses that the channels send back. Software changes the run bits and the mask bits through separate set and clear registers. A single write can therefore start or stop any subset of channels in the same clock edge, and channels started that way stay phase-aligned.

Captured period-end events stay in a pending register until software reads it. That read both returns the events and acknowledges them. One interrupt line to the system stays high while any pending event belongs to an unmasked channel. The channel counters, prescalers and output waveform logic sit outside this block.

The register port is a single-cycle access with a byte address. Word offsets are fixed because software decodes them: 0x00 reads zero, 0x04 sets run bits, 0x08 clears run bits, 0x0C reads the run bits, 0x10 sets mask bits, 0x14 clears mask bits, 0x18 reads the mask and 0x1C reads and acknowledges the pending events. Bit n of every register belongs to channel n.

Top module: `pwm_gate_top`

## Requirements
- R1: After reset, every run bit, mask bit and pending bit is 0, so `chanEnable` is 0 and `irqOut` is 0.
- R2: A write to offset 0x04 sets the run bit of each channel whose data bit is 1 and leaves the other run bits unchanged. `chanEnable` shows the result in the cycle after the write, and all selected channels change on the same edge.
- R3: A write to offset 0x08 clears the run bit of each channel whose data bit is 1 and leaves the other run bits unchanged, taking effect on the next edge.
- R4: A read of offset 0x0C returns the current run bits in the same cycle as the read strobe.
- R5: A write to offset 0x10 sets, and a write to offset 0x14 clears, the mask bit of each channel whose data bit is 1. A read of offset 0x18 returns the mask. A mask bit of 1 means the interrupt is enabled.
- R6: A 1 on `periodEnd[n]` in a cycle sets pending bit n at the next edge, whatever the state of the run bit or the mask bit. The bit stays set until it is acknowledged.
- R7: A read of offset 0x1C returns the pending bits in the same cycle and clears them at the edge that ends the read. An event arriving in that same cycle is kept pending.
- R8: `irqOut` is 1 exactly when some channel has both its pending bit and its mask bit set.
- R9: Writes to offsets 0x00, 0x0C, 0x18 and 0x1C change nothing. Any access whose two low address bits are not 00 is ignored: a write changes nothing, and a read returns 0 and does not acknowledge. Reads of any offset other than 0x0C, 0x18 and 0x1C return 0 and have no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W (5) | Byte address of the access |
| regWrData | input | N (4) | Write data, bit n for channel n |
| regRdData | output | N (4) | Read data, valid in the cycle of `regRdEn`; 0 when no read is active |
| periodEnd | input | N (4) | One-cycle period-end pulses from the channels |
| chanEnable | output | N (4) | Run bit of each channel |
| irqOut | output | 1 | Interrupt request |

## Verification
The hardest case is an event that lands in the same cycle as the acknowledging read. A design that clears the pending register without merging new events would drop that event, and `irqOut` would never follow it. Writes with several bits set, and writes with all bits zero, show whether set and clear touch only the selected channels. A full-register load instead of a bit-set would stop channels that were left out of the write. Misaligned addresses and writes to read-only offsets show whether the decoder is tight. A loose decoder would acknowledge events on a stray read or change the mask from a write to the mask readback. Random traffic then compares every output against a model each cycle, including interleaved mask changes around pending events.

// File: rtl/pwm_gate_pkg.sv
`timescale 1ns/1ps
package pwm_gate_pkg;

  // word index = byte address >> 2; software decodes these
  localparam int unsigned IDX_MODE     = 0;
  localparam int unsigned IDX_RUN_SET  = 1;
  localparam int unsigned IDX_RUN_CLR  = 2;
  localparam int unsigned IDX_RUN_STAT = 3;
  localparam int unsigned IDX_MSK_SET  = 4;
  localparam int unsigned IDX_MSK_CLR  = 5;
  localparam int unsigned IDX_MSK_STAT = 6;
  localparam int unsigned IDX_PEND     = 7;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_RUN,
    RD_MASK,
    RD_PEND
  } readSel_e;

  typedef struct packed {
    logic     runSet;
    logic     runClr;
    logic     maskSet;
    logic     maskClr;
    logic     pendAck;
    readSel_e readSel;
  } gateStrobe_t;

endpackage

// File: rtl/pwm_gate_ctrl.sv
`timescale 1ns/1ps
module pwm_gate_ctrl
  import pwm_gate_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output gateStrobe_t       strobe
);

  localparam int IDX_W = ADDR_W - 2;

  logic             aligned;
  logic [IDX_W-1:0] wordIdx;
  logic             wrOk;
  logic             rdOk;

  assign aligned = (regAddr[1:0] == 2'b00);
  assign wordIdx = regAddr[ADDR_W-1:2];
  assign wrOk    = regWrEn && aligned;
  assign rdOk    = regRdEn && aligned;

  always_comb begin
    strobe         = '0;
    strobe.readSel = RD_NONE;
    if (wrOk) begin
      strobe.runSet  = (wordIdx == IDX_W'(IDX_RUN_SET));
      strobe.runClr  = (wordIdx == IDX_W'(IDX_RUN_CLR));
      strobe.maskSet = (wordIdx == IDX_W'(IDX_MSK_SET));
      strobe.maskClr = (wordIdx == IDX_W'(IDX_MSK_CLR));
    end
    if (rdOk) begin
      if (wordIdx == IDX_W'(IDX_RUN_STAT)) begin
        strobe.readSel = RD_RUN;
      end else if (wordIdx == IDX_W'(IDX_MSK_STAT)) begin
        strobe.readSel = RD_MASK;
      end else if (wordIdx == IDX_W'(IDX_PEND)) begin
        strobe.readSel = RD_PEND;
        strobe.pendAck = 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm_gate_datapath.sv
`timescale 1ns/1ps
module pwm_gate_datapath
  import pwm_gate_pkg::*;
#(
  parameter int N = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  gateStrobe_t strobe,
  input  logic [N-1:0] wrData,
  input  logic [N-1:0] periodEnd,
  output logic [N-1:0] rdData,
  output logic [N-1:0] runQ,
  output logic [N-1:0] maskQ,
  output logic [N-1:0] pendQ,
  output logic        irq
);

  logic [N-1:0] hitVec;

  // per-channel bit slices: each channel owns one run, mask and pending flop
  for (genvar ch = 0; ch < N; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        runQ[ch]  <= 1'b0;
        maskQ[ch] <= 1'b0;
        pendQ[ch] <= 1'b0;
      end else begin
        if (strobe.runSet && wrData[ch]) begin
          runQ[ch] <= 1'b1;
        end else if (strobe.runClr && wrData[ch]) begin
          runQ[ch] <= 1'b0;
        end
        if (strobe.maskSet && wrData[ch]) begin
          maskQ[ch] <= 1'b1;
        end else if (strobe.maskClr && wrData[ch]) begin
          maskQ[ch] <= 1'b0;
        end
        // new event wins over the acknowledge in the same cycle
        if (periodEnd[ch]) begin
          pendQ[ch] <= 1'b1;
        end else if (strobe.pendAck) begin
          pendQ[ch] <= 1'b0;
        end
      end
    end
    assign hitVec[ch] = pendQ[ch] & maskQ[ch];
  end

  assign irq = |hitVec;

  always_comb begin
    unique case (strobe.readSel)
      RD_RUN:  rdData = runQ;
      RD_MASK: rdData = maskQ;
      RD_PEND: rdData = pendQ;
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/pwm_gate_top.sv
`timescale 1ns/1ps
module pwm_gate_top
  import pwm_gate_pkg::*;
#(
  parameter int N      = 4,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [N-1:0]      regWrData,
  output logic [N-1:0]      regRdData,
  input  logic [N-1:0]      periodEnd,
  output logic [N-1:0]      chanEnable,
  output logic              irqOut
);

  gateStrobe_t  strobe;
  logic [N-1:0] runQ;
  logic [N-1:0] maskQ;
  logic [N-1:0] pendQ;

  pwm_gate_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  pwm_gate_datapath #(.N(N)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (regWrData),
    .periodEnd (periodEnd),
    .rdData    (regRdData),
    .runQ      (runQ),
    .maskQ     (maskQ),
    .pendQ     (pendQ),
    .irq       (irqOut)
  );

  assign chanEnable = runQ;

endmodule

// File: rtl/pwm_gate_checker.sv
`timescale 1ns/1ps
module pwm_gate_checker #(
  parameter int N      = 4,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [N-1:0]      regWrData,
  input logic [N-1:0]      regRdData,
  input logic [N-1:0]      periodEnd,
  input logic [N-1:0]      chanEnable,
  input logic              irqOut,
  input logic [N-1:0]      maskQ,
  input logic [N-1:0]      pendQ
);

  logic aligned;
  logic runSetWr;
  logic runClrWr;
  logic maskSetWr;
  logic ackRd;
  logic anyRead;

  assign aligned   = (regAddr[1:0] == 2'b00);
  assign runSetWr  = regWrEn && aligned && (regAddr == ADDR_W'(5'h04));
  assign runClrWr  = regWrEn && aligned && (regAddr == ADDR_W'(5'h08));
  assign maskSetWr = regWrEn && aligned && (regAddr == ADDR_W'(5'h10));
  assign ackRd     = regRdEn && aligned && (regAddr == ADDR_W'(5'h1C));
  assign anyRead   = regRdEn && aligned &&
                     ((regAddr == ADDR_W'(5'h0C)) || (regAddr == ADDR_W'(5'h18)) ||
                      (regAddr == ADDR_W'(5'h1C)));

  AST_RUN_SET: assert property (@(posedge clk) disable iff (!rstN)
    runSetWr |=> ((chanEnable & $past(regWrData)) == $past(regWrData))); // R2

  AST_RUN_CLR: assert property (@(posedge clk) disable iff (!rstN)
    runClrWr |=> ((chanEnable & $past(regWrData)) == '0)); // R3

  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(runSetWr || runClrWr) |=> $stable(chanEnable)); // R9

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (ackRd && (periodEnd == '0)) |=> (pendQ == '0)); // R7

  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (|periodEnd) |=> ((pendQ & $past(periodEnd)) == $past(periodEnd))); // R6

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> ($past(|periodEnd) || $past(maskSetWr))); // R8

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !anyRead |-> (regRdData == '0)); // R9

endmodule

bind pwm_gate_top pwm_gate_checker #(.N(N), .ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_pwm_gate_top.sv
`timescale 1ns/1ps
module test_pwm_gate_top;

  localparam int N      = 4;
  localparam int ADDR_W = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWrEn = 1'b0;
  logic              regRdEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [N-1:0]      regWrData = '0;
  logic [N-1:0]      regRdData;
  logic [N-1:0]      periodEnd = '0;
  logic [N-1:0]      chanEnable;
  logic              irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [N-1:0] mRun  = '0;
  logic [N-1:0] mMask = '0;
  logic [N-1:0] mPend = '0;

  always #2 clk = ~clk;

  pwm_gate_top #(.N(N), .ADDR_W(ADDR_W)) i_pwm_gate_top (.*);

  function automatic logic [N-1:0] expRead(logic rd, logic [ADDR_W-1:0] a);
    if (!rd || a[1:0] != 2'b00) return '0;
    case (a)
      5'h0C:   return mRun;
      5'h18:   return mMask;
      5'h1C:   return mPend;
      default: return '0;
    endcase
  endfunction

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic r, input logic [ADDR_W-1:0] a,
                      input logic [N-1:0] d, input logic [N-1:0] ev, input string tag);
    @(negedge clk);
    regWrEn = w; regRdEn = r; regAddr = a; regWrData = d; periodEnd = ev;
    #1;
    check(chanEnable, mRun, {tag, " run R2 R3"});
    check(irqOut, |(mPend & mMask), {tag, " irq R8"});
    check(regRdData, expRead(r, a), {tag, " rdata R4 R5 R7 R9"});
    @(posedge clk);
    if (w && a[1:0] == 2'b00) begin
      case (a)
        5'h04: mRun  = mRun | d;
        5'h08: mRun  = mRun & ~d;
        5'h10: mMask = mMask | d;
        5'h14: mMask = mMask & ~d;
        default: ;
      endcase
    end
    if (r && a == 5'h1C) mPend = ev;
    else                 mPend = mPend | ev;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R1 reset state
    step(0, 1, 5'h0C, 0, 0, "R1 run");
    step(0, 1, 5'h18, 0, 0, "R1 mask");
    step(0, 1, 5'h1C, 0, 0, "R1 pend");
    // R2 multi-bit set, then zero write
    step(1, 0, 5'h04, 4'b0101, 0, "R2 set");
    step(1, 0, 5'h04, 4'b0000, 0, "R2 zero");
    step(1, 0, 5'h04, 4'b1000, 0, "R2 add");
    step(0, 1, 5'h0C, 0, 0, "R4 status");
    // R3 clear two at once
    step(1, 0, 5'h08, 4'b1001, 0, "R3 clr");
    step(1, 0, 5'h08, 4'b0000, 0, "R3 zero");
    // R9 writes to read-only offsets and misaligned
    step(1, 0, 5'h0C, 4'b1111, 0, "R9 ro");
    step(1, 0, 5'h18, 4'b1111, 0, "R9 ro");
    step(1, 0, 5'h05, 4'b1111, 0, "R9 misaligned");
    step(1, 0, 5'h11, 4'b1111, 0, "R9 misaligned");
    // R5 mask
    step(1, 0, 5'h10, 4'b0110, 0, "R5 mset");
    step(1, 0, 5'h14, 4'b0010, 0, "R5 mclr");
    step(0, 1, 5'h18, 0, 0, "R5 mread");
    // R6 event on masked-off channel: pending, no irq
    step(0, 0, 5'h00, 0, 4'b0001, "R6 ev");
    step(0, 1, 5'h1D, 0, 0, "R9 misaligned read no ack");
    step(0, 1, 5'h00, 0, 0, "R9 mode read");
    // R8 event on enabled channel raises irq
    step(0, 0, 5'h00, 0, 4'b0100, "R8 ev");
    step(0, 0, 5'h00, 0, 0, "R8 irq");
    // R7 ack with a simultaneous event
    step(0, 1, 5'h1C, 0, 4'b0100, "R7 ack+ev");
    step(0, 1, 5'h1C, 0, 0, "R7 kept");
    step(0, 1, 5'h1C, 0, 0, "R7 empty");
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic w, r;
      logic [ADDR_W-1:0] a;
      logic [N-1:0] d, ev;
      w  = ($urandom % 3) == 0;
      r  = ($urandom % 3) == 0;
      a  = (($urandom % 8) == 0) ? ADDR_W'($urandom) : ADDR_W'(($urandom % 8) * 4);
      d  = N'($urandom);
      ev = (($urandom % 4) == 0) ? N'($urandom) : '0;
      step(w, r, a, d, ev, "RND");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule